// File: doc/BRIEF.md
# Pointer Effective-Address Unit

This unit works out the memory address for a load or store that goes through a pointer register. The surrounding pipeline reads one of the 32 pointer-capable registers (16 in each of two banks) and hands its value to the unit. With it come an addressing-mode code, a direction bit, an optional element displacement and the access size. In the same cycle the unit returns the address for the memory port, the pointer value to write back and a write-back enable.

Four linear modes are covered:
- **Indirect**: the pointer is used as it is.
- **Pre-modify**: the pointer is moved first, and the moved value goes to memory.
- **Post-modify**: memory sees the old pointer, and the moved value is written back.
- **Offset**: memory sees the pointer plus the displacement, and the register is left as it was.

The displacement counts elements, so it is scaled by the access size before it is used. All address arithmetic wraps modulo 2^32. The unit holds no state; any registers around it belong to the pipeline.

Top module: `ptr_agen`

## Requirements
- R1: The step is the element count shifted left by the size code. Size codes are 0 = byte (shift 0), 1 = halfword (shift 1), 2 = word (shift 2), and 3 is treated as word (shift 2).
- R2: With `amode` = 0 (indirect), `mem_addr` and `ptr_next` both equal `ptr_in`, whatever the values of `sub`, `disp`, `disp_valid` and `size`.
- R3: With `amode` = 2 (post-modify), `mem_addr` equals `ptr_in` and `ptr_next` equals the pointer moved by the step.
- R4: With `amode` = 1 (pre-modify), `mem_addr` and `ptr_next` both equal the pointer moved by the step.
- R5: With `amode` = 3 (offset), `mem_addr` equals the pointer moved by the step and `ptr_next` equals `ptr_in`.
- R6: `wb_en` is 1 exactly when `amode` is 1 or 2. In every other mode `ptr_next` equals `ptr_in`.
- R7: When `disp_valid` is 0, the element count is 1 and `disp` is ignored.
- R8: Address arithmetic wraps modulo 2^32 in both directions, and no flag is raised.
- R9: `sub` = 1 subtracts the step and `sub` = 0 adds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ptr_in | input | 32 | Current value of the selected pointer register |
| amode | input | 2 | 0 indirect, 1 pre-modify, 2 post-modify, 3 offset |
| sub | input | 1 | 1 = move downward, 0 = move upward |
| disp | input | 5 | Displacement in elements |
| disp_valid | input | 1 | 1 = use `disp`, 0 = element count of 1 |
| size | input | 2 | Access size code for scaling |
| mem_addr | output | 32 | Address presented to memory |
| ptr_next | output | 32 | Pointer value to write back |
| wb_en | output | 1 | Write the pointer back to the register file |

## Verification
Every output is a pure function of the current inputs, so each result is due in the same cycle as its stimulus, with zero register stages in between. The bench drives a new vector just after each falling clock edge and compares all three outputs two nanoseconds later. The comparison therefore happens well before the next rising edge, against a behavioural model evaluated on the same vector. Directed vectors cover each mode, both directions, every size code, the default displacement and wrap-around at both ends of the address space. A seeded pseudo-random stream then changes the vector on every clock.

// File: rtl/ptr_agen.sv
module ptr_agen #(
  parameter int AW = 32,
  parameter int DW = 5
) (
  input  logic [AW-1:0] ptr_in,
  input  logic [1:0]    amode,
  input  logic          sub,
  input  logic [DW-1:0] disp,
  input  logic          disp_valid,
  input  logic [1:0]    size,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] ptr_next,
  output logic          wb_en
);
  localparam logic [1:0] M_IND  = 2'd0;
  localparam logic [1:0] M_PRE  = 2'd1;
  localparam logic [1:0] M_POST = 2'd2;
  localparam logic [1:0] M_OFS  = 2'd3;
  localparam int         PADW   = AW - DW;

  logic [DW-1:0] elems;
  logic [1:0]    shamt;
  logic [AW-1:0] step;
  logic [AW-1:0] moved;

  assign elems = disp_valid ? disp : DW'(1);
  assign shamt = (size == 2'd0) ? 2'd0 : (size == 2'd1) ? 2'd1 : 2'd2;
  assign step  = {{PADW{1'b0}}, elems} << shamt;
  assign moved = sub ? (ptr_in - step) : (ptr_in + step);

  always_comb begin
    mem_addr = ptr_in;
    ptr_next = ptr_in;
    wb_en    = 1'b0;
    case (amode)
      M_PRE: begin
        mem_addr = moved;
        ptr_next = moved;
        wb_en    = 1'b1;
      end
      M_POST: begin
        ptr_next = moved;
        wb_en    = 1'b1;
      end
      M_OFS:   mem_addr = moved;
      M_IND:   ;
      default: ;
    endcase
  end
endmodule

// File: rtl/ptr_agen_chk.sv
module ptr_agen_chk #(
  parameter int AW = 32,
  parameter int DW = 5
) (
  input logic [AW-1:0] ptr_in,
  input logic [1:0]    amode,
  input logic          sub,
  input logic [DW-1:0] disp,
  input logic          disp_valid,
  input logic [1:0]    size,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] ptr_next,
  input logic          wb_en
);
  logic unused_ok;
  assign unused_ok = ^{sub, disp, disp_valid, size};

  always_comb begin
    AST_IND_PASS: assert (amode != 2'd0 || (mem_addr == ptr_in && ptr_next == ptr_in)) else $error("indirect changed pointer"); // R2
    AST_POST_OLD: assert (amode != 2'd2 || mem_addr == ptr_in) else $error("post used new pointer"); // R3
    AST_PRE_NEW: assert (amode != 2'd1 || mem_addr == ptr_next) else $error("pre address mismatch"); // R4
    AST_OFS_KEEP: assert (amode != 2'd3 || ptr_next == ptr_in) else $error("offset modified pointer"); // R5
    AST_WB_MODE: assert (wb_en == (amode[0] ^ amode[1])) else $error("write-back enable wrong"); // R6
    AST_NOWB_HOLD: assert (wb_en || ptr_next == ptr_in) else $error("pointer moved without write-back"); // R6
  end
endmodule

bind ptr_agen ptr_agen_chk #(.AW(AW), .DW(DW)) u_chk (
  .ptr_in(ptr_in), .amode(amode), .sub(sub), .disp(disp),
  .disp_valid(disp_valid), .size(size), .mem_addr(mem_addr),
  .ptr_next(ptr_next), .wb_en(wb_en)
);

// File: tb/tb_ptr_agen.sv
`timescale 1ns/1ps
module tb_ptr_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ptr_in = '0;
  logic [1:0]  amode = '0;
  logic        sub = 1'b0;
  logic [4:0]  disp = '0;
  logic        disp_valid = 1'b0;
  logic [1:0]  size = '0;
  logic [31:0] mem_addr, ptr_next;
  logic        wb_en;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ptr_agen dut (
    .ptr_in(ptr_in), .amode(amode), .sub(sub), .disp(disp),
    .disp_valid(disp_valid), .size(size),
    .mem_addr(mem_addr), .ptr_next(ptr_next), .wb_en(wb_en)
  );

  task automatic apply(input string tag, input logic [31:0] p, input logic [1:0] m,
                       input logic s, input logic [4:0] d, input logic dv, input logic [1:0] z);
    longint unsigned bytes, moved;
    logic [31:0] e_addr, e_next;
    logic e_wb;
    @(negedge clk);
    ptr_in = p; amode = m; sub = s; disp = d; disp_valid = dv; size = z;
    bytes = (dv ? longint'(d) : 1) * ((z == 0) ? 1 : (z == 1) ? 2 : 4);
    moved = s ? (longint'(p) + 64'h1_0000_0000 - bytes) : (longint'(p) + bytes);
    moved = moved % 64'h1_0000_0000;
    e_addr = p; e_next = p; e_wb = 1'b0;
    if (m == 1) begin e_addr = moved[31:0]; e_next = moved[31:0]; e_wb = 1'b1; end
    else if (m == 2) begin e_next = moved[31:0]; e_wb = 1'b1; end
    else if (m == 3) e_addr = moved[31:0];
    #2;
    n_vec++;
    if (mem_addr !== e_addr || ptr_next !== e_next || wb_en !== e_wb) begin
      n_bad++;
      $display("FAIL %s: addr=%h next=%h wb=%b expected addr=%h next=%h wb=%b",
               tag, mem_addr, ptr_next, wb_en, e_addr, e_next, e_wb);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply("R6 idle inputs", 32'h0, 2'd0, 1'b0, 5'd0, 1'b0, 2'd0);
    apply("R2 indirect ignores disp", 32'h0000_1000, 2'd0, 1'b1, 5'd7, 1'b1, 2'd2);
    apply("R3 post inc word", 32'h0000_2000, 2'd2, 1'b0, 5'd3, 1'b1, 2'd2);
    apply("R9 post dec half", 32'h0000_2000, 2'd2, 1'b1, 5'd2, 1'b1, 2'd1);
    apply("R4 pre inc byte", 32'h0000_1000, 2'd1, 1'b0, 5'd5, 1'b1, 2'd0);
    apply("R7 pre dec default disp", 32'h0000_1000, 2'd1, 1'b1, 5'd9, 1'b0, 2'd2);
    apply("R5 offset word", 32'h0000_0100, 2'd3, 1'b0, 5'd31, 1'b1, 2'd2);
    apply("R8 wrap up", 32'hFFFF_FFFC, 2'd2, 1'b0, 5'd1, 1'b1, 2'd2);
    apply("R8 wrap down", 32'h0000_0000, 2'd1, 1'b1, 5'd1, 1'b1, 2'd0);
    apply("R1 size code 3", 32'h0000_0040, 2'd2, 1'b0, 5'd1, 1'b1, 2'd3);
    apply("R1 half offset", 32'h0000_0040, 2'd3, 1'b0, 5'd31, 1'b1, 2'd1);
    apply("R7 offset default byte", 32'h0000_0040, 2'd3, 1'b1, 5'd31, 1'b0, 2'd0);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rp;
      logic [1:0] rm;
      rp = $urandom;
      rm = 2'($urandom);
      apply((rm == 0) ? "R2 random" : (rm == 1) ? "R4 random" : (rm == 2) ? "R3 random" : "R5 random",
            (i % 16 == 0) ? {28'hFFFF_FFF, rp[3:0]} : rp, rm, 1'($urandom), 5'($urandom),
            1'($urandom), 2'($urandom));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule